// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is the host-side controller for an 8-bit multiplexed NAND flash bus. A client hands it one operation at a time (page read, page program, block erase, status read, ID read or device reset) together with a 12-bit column and a 16-bit row. The block then sends the right command bytes, address bytes and data bytes over the shared I/O lines. It drives the chip-enable, command-latch, address-latch, write and read strobes. It also waits on the ready/busy line while the device works internally.

Page data moves over two byte streams. Program bytes are pulled with a valid/ready pair. Read bytes are pushed out with a one-cycle valid strobe. Every strobe width, setup/hold time and inter-phase gap is a parameter counted in system clock cycles. The default values suit a 200 MHz clock. When a program or erase ends, the block reads the device status on its own and reports the pass/fail bit. A watchdog on the busy line aborts an operation whose busy period runs past a parameterised limit.

Top module: `nand_seq`

## Requirements
- R1: Out of reset and whenever idle, chip enable, write strobe and read strobe are high, both latch enables are low, the I/O lines are not driven, and `req_ready_o` is high.
- R2: Operation codes on `req_op_i`, with the opcode bytes each one sends:
  - 0 = page read: 00h, then 30h.
  - 1 = page program: 80h, then 10h.
  - 2 = block erase: 60h, then D0h.
  - 3 = status: 70h.
  - 4 = ID: 90h.
  - 5 = reset: FFh.
- R3: Read and program send four address bytes after the first command, in this order:
  - column bits 7..0;
  - column bits 11..8 in bits 3..0, with bits 7..4 zero;
  - row bits 7..0;
  - row bits 15..8.
- R4: Erase sends exactly two address bytes, row bits 7..0 and then row bits 15..8, and no column bytes.
- R5: Command bytes carry CLE=1 and ALE=0. Address bytes carry ALE=1 and CLE=0. Data bytes carry both low. Every byte is held stable on the I/O lines across the write-strobe rising edge, with chip enable low.
- R6: At least `ADL_CYC` cycles pass between the write-strobe rising edge of the last address byte and that of the first program data byte.
- R7: After a confirming command (30h, 10h, D0h or FFh), ready/busy is not sampled for `WB_CYC` cycles. The operation does not move on until the line has gone low and come back high.
- R8: At least `WHR_CYC` cycles pass between the write-strobe rising edge of 70h and the first read-strobe falling edge.
- R9: A page read returns `PAGE_BYTES` bytes on `rdata_o` in device order, with one read-strobe pulse per byte. The read strobe never falls while the block drives the I/O lines.
- R10: Status reporting:
  - Program and erase each end with an automatic 70h status read, and `fail_o` equals bit 0 of that status byte.
  - A status request sends 70h alone, streams the byte out on `rdata_o` and sets `fail_o` from its bit 0.
- R11: If ready/busy stays low for `BUSY_MAX` sampled cycles, the operation ends with `timeout_o` high and no status command is sent.
- R12: A program writes `PAGE_BYTES` bytes taken from the write stream in order, one byte per `wdata_ready_o` pulse.
- R13: An ID read sends 90h, then a single address byte 00h, then returns `ID_BYTES` bytes on `rdata_o`.
- R14: A reset sends FFh and finishes only after the busy period that follows it has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Operation request |
| req_ready_o | output | 1 | Sequencer idle; a request is taken when both are high |
| req_op_i | input | 3 | Operation code (see R2) |
| req_col_i | input | 12 | Column address |
| req_row_i | input | 16 | Row (page) address |
| wdata_i | input | 8 | Program data byte |
| wdata_valid_i | input | 1 | Program byte available |
| wdata_ready_o | output | 1 | Program byte consumed this cycle |
| rdata_o | output | 8 | Read/ID/status byte |
| rdata_valid_o | output | 1 | `rdata_o` valid this cycle |
| done_o | output | 1 | One-cycle pulse at the end of an operation |
| fail_o | output | 1 | Status fail bit, valid with `done_o` |
| timeout_o | output | 1 | Busy timeout, valid with `done_o` |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | I/O output byte |
| nand_dq_oe_o | output | 1 | I/O output enable |
| nand_dq_i | input | 8 | I/O input byte |
| nand_rb_ni | input | 1 | Ready/busy, low while busy |

## Verification
The hardest situations to reach are the ones where the block waits for the device: the hold-off after a confirming command, and the busy timeout.

A device that answers too quickly hides a missing hold-off. The bench therefore uses a flash model that pulls ready/busy low only a few cycles after the confirming write-strobe edge. A sequencer that samples too early sees the line still high and finishes before the release, and the bench catches that.

The timeout is reached by making the model hold the line low for far longer than the lowered `BUSY_MAX`. The bench then checks that no 70h byte follows.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_STATUS = 3'd3,
    OP_ID     = 3'd4,
    OP_RESET  = 3'd5
  } nand_op_e;

  localparam logic [7:0] CMD_STATUS = 8'h70;

  function automatic logic [7:0] lead_cmd(nand_op_e op);
    case (op)
      OP_READ:  return 8'h00;
      OP_PROG:  return 8'h80;
      OP_ERASE: return 8'h60;
      OP_ID:    return 8'h90;
      OP_RESET: return 8'hFF;
      default:  return CMD_STATUS;
    endcase
  endfunction

  function automatic logic [7:0] confirm_cmd(nand_op_e op);
    case (op)
      OP_READ:  return 8'h30;
      OP_PROG:  return 8'h10;
      default:  return 8'hD0;
    endcase
  endfunction
endpackage

// File: rtl/nand_gap_timer.sv
module nand_gap_timer #(
  parameter int GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [GW-1:0] value_i,
  output logic          expired_o
);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= value_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0) && !load_i;
endmodule

// File: rtl/nand_busy_mon.sv
module nand_busy_mon #(
  parameter int BUSY_MAX = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic rb_ni,
  output logic ready_o,
  output logic timeout_o
);
  localparam int TW = $clog2(BUSY_MAX + 1);

  logic          rb_s1, rb_s2;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_s1 <= 1'b1;
      rb_s2 <= 1'b1;
      cnt_q <= '0;
    end else begin
      rb_s1 <= rb_ni;
      rb_s2 <= rb_s1;
      if (!arm_i)                                  cnt_q <= '0;
      else if (!rb_s2 && cnt_q != TW'(BUSY_MAX))   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o   = arm_i && rb_s2;
  assign timeout_o = arm_i && !rb_s2 && (cnt_q == TW'(BUSY_MAX));
endmodule

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle #(
  parameter int SETUP_CYC = 1,
  parameter int WP_CYC    = 2,
  parameter int WH_CYC    = 2,
  parameter int RP_CYC    = 2,
  parameter int REH_CYC   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] dq_i,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  output logic       done_o,
  output logic       rd_done_o,
  output logic [7:0] rdata_o
);
  localparam int M1   = (SETUP_CYC > WP_CYC) ? SETUP_CYC : WP_CYC;
  localparam int M2   = (WH_CYC > RP_CYC) ? WH_CYC : RP_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > REH_CYC) ? M3 : REH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {CG_IDLE, CG_SETUP, CG_LOW, CG_HIGH} cg_e;

  cg_e           st_q;
  logic [CW-1:0] cnt_q;
  logic          rd_q, cle_q, ale_q;
  logic [7:0]    byte_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= CG_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      byte_q  <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        CG_IDLE: if (start_i) begin
          st_q   <= CG_SETUP;
          cnt_q  <= CW'(SETUP_CYC - 1);
          rd_q   <= rd_i;
          cle_q  <= cle_i;
          ale_q  <= ale_i;
          byte_q <= byte_i;
        end
        CG_SETUP: if (cnt_q == '0) begin
          st_q  <= CG_LOW;
          cnt_q <= rd_q ? CW'(RP_CYC - 1) : CW'(WP_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        CG_LOW: if (cnt_q == '0) begin
          st_q  <= CG_HIGH;
          cnt_q <= rd_q ? CW'(REH_CYC - 1) : CW'(WH_CYC - 1);
          if (rd_q) rdata_q <= dq_i;  // sample at end of access window
        end else cnt_q <= cnt_q - 1'b1;
        CG_HIGH: if (cnt_q == '0) begin
          st_q  <= CG_IDLE;
          cle_q <= 1'b0;
          ale_q <= 1'b0;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= CG_IDLE;
      endcase
    end
  end

  assign cle_o     = cle_q && (st_q != CG_IDLE);
  assign ale_o     = ale_q && (st_q != CG_IDLE);
  assign we_no     = !((st_q == CG_LOW) && !rd_q);
  assign re_no     = !((st_q == CG_LOW) && rd_q);
  assign dq_o      = byte_q;
  assign dq_oe_o   = (st_q != CG_IDLE) && !rd_q;
  assign done_o    = (st_q == CG_HIGH) && (cnt_q == '0);
  assign rd_done_o = done_o && rd_q;
  assign rdata_o   = rdata_q;

  assert_dq_stable_at_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> ($stable(dq_o) && dq_oe_o));
  assert_no_drive_while_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !dq_oe_o);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 2112,
  parameter int ID_BYTES   = 4,
  parameter int SETUP_CYC  = 1,
  parameter int WP_CYC     = 3,
  parameter int WH_CYC     = 2,
  parameter int RP_CYC     = 3,
  parameter int REH_CYC    = 2,
  parameter int ADL_CYC    = 20,
  parameter int WB_CYC     = 20,
  parameter int WHR_CYC    = 12,
  parameter int RR_CYC     = 4,
  parameter int BUSY_MAX   = 1000000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [2:0]  req_op_i,
  input  logic [11:0] req_col_i,
  input  logic [15:0] req_row_i,
  input  logic [7:0]  wdata_i,
  input  logic        wdata_valid_i,
  output logic        wdata_ready_o,
  output logic [7:0]  rdata_o,
  output logic        rdata_valid_o,
  output logic        done_o,
  output logic        fail_o,
  output logic        timeout_o,
  output logic        nand_ce_no,
  output logic        nand_cle_o,
  output logic        nand_ale_o,
  output logic        nand_we_no,
  output logic        nand_re_no,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe_o,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb_ni
);
  localparam int IMAX = (PAGE_BYTES > 4) ? PAGE_BYTES : 4;
  localparam int IW   = $clog2(IMAX + 1);
  localparam int G1   = (ADL_CYC > WB_CYC) ? ADL_CYC : WB_CYC;
  localparam int G2   = (WHR_CYC > RR_CYC) ? WHR_CYC : RR_CYC;
  localparam int GMAX = (G1 > G2) ? G1 : G2;
  localparam int GW   = $clog2(GMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_ADL, S_WDATA, S_CMD2,
    S_WB, S_BUSY, S_SCMD, S_WHR, S_RDATA, S_DONE
  } st_e;

  st_e           st_q;
  nand_op_e      op_q;
  logic [11:0]   col_q;
  logic [15:0]   row_q;
  logic [IW-1:0] idx_q, n_addr, n_read, sel;
  logic          launched_q, fail_q, tmo_q;
  logic          bus_st, gap_st, cg_start, cg_done, cg_rd_done, gap_load, gap_exp;
  logic          bm_ready, bm_tmo;
  logic [7:0]    cg_byte, addr_byte, cg_rdata;
  logic [GW-1:0] gap_val;

  always_comb begin
    unique case (op_q)
      OP_READ, OP_PROG: n_addr = IW'(4);
      OP_ERASE:         n_addr = IW'(2);
      default:          n_addr = IW'(1);
    endcase
    unique case (op_q)
      OP_READ: n_read = IW'(PAGE_BYTES);
      OP_ID:   n_read = IW'(ID_BYTES);
      default: n_read = IW'(1);
    endcase
    sel = (op_q == OP_ERASE) ? idx_q + IW'(2) : idx_q;
    if (op_q == OP_ID)        addr_byte = 8'h00;
    else if (sel == IW'(0))   addr_byte = col_q[7:0];
    else if (sel == IW'(1))   addr_byte = {4'h0, col_q[11:8]};
    else if (sel == IW'(2))   addr_byte = row_q[7:0];
    else                      addr_byte = row_q[15:8];
    unique case (st_q)
      S_CMD1:  cg_byte = lead_cmd(op_q);
      S_CMD2:  cg_byte = confirm_cmd(op_q);
      S_SCMD:  cg_byte = CMD_STATUS;
      S_ADDR:  cg_byte = addr_byte;
      S_WDATA: cg_byte = wdata_i;
      default: cg_byte = 8'h00;
    endcase
    unique case (st_q)
      S_ADL:   gap_val = GW'(ADL_CYC - 1);
      S_WB:    gap_val = GW'(WB_CYC - 1);
      default: gap_val = (op_q == OP_READ) ? GW'(RR_CYC - 1) : GW'(WHR_CYC - 1);
    endcase
  end

  assign bus_st   = st_q inside {S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_SCMD, S_RDATA};
  assign gap_st   = st_q inside {S_ADL, S_WB, S_WHR};
  assign cg_start = bus_st && !launched_q && (st_q != S_WDATA || wdata_valid_i);
  assign gap_load = gap_st && !launched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; op_q <= OP_READ; col_q <= '0; row_q <= '0;
      idx_q <= '0; launched_q <= 1'b0; fail_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      if (cg_start || gap_load) launched_q <= 1'b1;
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          op_q  <= nand_op_e'(req_op_i);
          col_q <= req_col_i;
          row_q <= req_row_i;
          fail_q <= 1'b0;
          tmo_q  <= 1'b0;
          idx_q  <= '0;
          if (req_op_i > 3'd5)               st_q <= S_DONE;
          else if (req_op_i == 3'(OP_STATUS)) st_q <= S_SCMD;
          else                               st_q <= S_CMD1;
        end
        S_CMD1: if (cg_done) begin
          launched_q <= 1'b0;
          st_q <= (op_q == OP_RESET) ? S_WB : S_ADDR;
        end
        S_ADDR: if (cg_done) begin
          launched_q <= 1'b0;
          if (idx_q == n_addr - 1'b1) begin
            idx_q <= '0;
            if (op_q == OP_PROG)    st_q <= S_ADL;
            else if (op_q == OP_ID) st_q <= S_WHR;
            else                    st_q <= S_CMD2;
          end else idx_q <= idx_q + 1'b1;
        end
        S_ADL: if (launched_q && gap_exp) begin launched_q <= 1'b0; st_q <= S_WDATA; end
        S_WDATA: if (cg_done) begin
          launched_q <= 1'b0;
          if (idx_q == IW'(PAGE_BYTES - 1)) begin idx_q <= '0; st_q <= S_CMD2; end
          else idx_q <= idx_q + 1'b1;
        end
        S_CMD2: if (cg_done) begin launched_q <= 1'b0; st_q <= S_WB; end
        S_WB:   if (launched_q && gap_exp) begin launched_q <= 1'b0; st_q <= S_BUSY; end
        S_BUSY:
          if (bm_tmo) begin
            tmo_q <= 1'b1;
            st_q  <= S_DONE;
          end else if (bm_ready) begin
            unique case (op_q)
              OP_READ:  st_q <= S_WHR;
              OP_RESET: st_q <= S_DONE;
              default:  st_q <= S_SCMD;
            endcase
          end
        S_SCMD: if (cg_done) begin launched_q <= 1'b0; st_q <= S_WHR; end
        S_WHR:  if (launched_q && gap_exp) begin launched_q <= 1'b0; idx_q <= '0; st_q <= S_RDATA; end
        S_RDATA: if (cg_done) begin
          launched_q <= 1'b0;
          if (op_q inside {OP_PROG, OP_ERASE, OP_STATUS}) fail_q <= cg_rdata[0];
          if (idx_q == n_read - 1'b1) st_q <= S_DONE;
          else idx_q <= idx_q + 1'b1;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  nand_bus_cycle #(
    .SETUP_CYC(SETUP_CYC), .WP_CYC(WP_CYC), .WH_CYC(WH_CYC),
    .RP_CYC(RP_CYC), .REH_CYC(REH_CYC)
  ) u_cycle (
    .clk_i, .rst_ni,
    .start_i(cg_start), .rd_i(st_q == S_RDATA),
    .cle_i(st_q inside {S_CMD1, S_CMD2, S_SCMD}), .ale_i(st_q == S_ADDR),
    .byte_i(cg_byte), .dq_i(nand_dq_i),
    .cle_o(nand_cle_o), .ale_o(nand_ale_o), .we_no(nand_we_no), .re_no(nand_re_no),
    .dq_o(nand_dq_o), .dq_oe_o(nand_dq_oe_o),
    .done_o(cg_done), .rd_done_o(cg_rd_done), .rdata_o(cg_rdata)
  );

  nand_gap_timer #(.GW(GW)) u_gap (
    .clk_i, .rst_ni, .load_i(gap_load), .value_i(gap_val), .expired_o(gap_exp)
  );

  nand_busy_mon #(.BUSY_MAX(BUSY_MAX)) u_busy (
    .clk_i, .rst_ni, .arm_i(st_q == S_BUSY), .rb_ni(nand_rb_ni),
    .ready_o(bm_ready), .timeout_o(bm_tmo)
  );

  assign req_ready_o   = (st_q == S_IDLE);
  assign wdata_ready_o = (st_q == S_WDATA) && cg_start;
  assign rdata_o       = cg_rdata;
  assign rdata_valid_o = cg_rd_done && (op_q inside {OP_READ, OP_ID, OP_STATUS});
  assign done_o        = (st_q == S_DONE);
  assign fail_o        = fail_q;
  assign timeout_o     = tmo_q;
  assign nand_ce_no    = (st_q == S_IDLE) || (st_q == S_DONE);

  assert_latch_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  assert_strobe_needs_ce_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (nand_ce_no && nand_we_no && nand_re_no && !nand_dq_oe_o));
  assert_timeout_aborts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_BUSY && bm_tmo) |=> (done_o && timeout_o));
endmodule

// File: tb/nand_seq_test.sv
`timescale 1ns/1ps
module nand_seq_test;
  localparam int PB = 6, IDB = 4, ADL = 20, WB = 20, WHR = 12, BMAX = 300;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [11:0] req_col = '0;
  logic [15:0] req_row = '0;
  logic [7:0] wdata;
  logic wdata_ready, rdata_valid, done, fail, tmo;
  logic [7:0] rdata;
  logic ce_n, cle, ale, we_n, re_n, dq_oe, rb_n = 1'b1;
  logic [7:0] dq_o, dq_in = '0;

  nand_seq #(.PAGE_BYTES(PB), .ID_BYTES(IDB), .ADL_CYC(ADL), .WB_CYC(WB),
             .WHR_CYC(WHR), .BUSY_MAX(BMAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_col_i(req_col), .req_row_i(req_row),
    .wdata_i(wdata), .wdata_valid_i(1'b1), .wdata_ready_o(wdata_ready),
    .rdata_o(rdata), .rdata_valid_o(rdata_valid), .done_o(done), .fail_o(fail),
    .timeout_o(tmo), .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe),
    .nand_dq_i(dq_in), .nand_rb_ni(rb_n));

  int cyc = 0, n_cmp = 0, n_bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // program data source
  int wk = 0;
  assign wdata = 8'(8'h40 + wk);
  always @(posedge clk) if (wdata_ready) wk <= wk + 1;

  // flash model state
  logic [7:0] lb [0:63];
  int lk [0:63];
  int lt [0:63];
  logic [7:0] rd [0:63];
  int ln = 0, rn = 0, rk = 0, re_cnt = 0, re_first = 0, rb_rel = -1;
  int rb_wait = 0, rb_left = 0, busy_len = 30;
  logic [7:0] last_cmd = 8'h00, stat_byte = 8'hE0;
  logic pwe = 1'b1, pre = 1'b1;

  function automatic logic [7:0] rpat(int k);
    return 8'(k * 7 + 3);
  endfunction

  always @(negedge clk) begin
    if (we_n && !pwe && ln < 64) begin
      lb[ln] = dq_o; lk[ln] = cle ? 0 : (ale ? 1 : 2); lt[ln] = cyc; ln++;
      if (cle) begin
        last_cmd = dq_o; rk = 0;
        if (dq_o == 8'h30 || dq_o == 8'h10 || dq_o == 8'hD0 || dq_o == 8'hFF) rb_wait = 3;
      end
    end
    if (!re_n && pre) begin
      re_cnt++;
      if (re_cnt == 1) re_first = cyc;
      dq_in = (last_cmd == 8'h70) ? stat_byte : (last_cmd == 8'h90) ? 8'(8'hA0 + rk) : rpat(rk);
      rk++;
    end
    if (rb_wait > 0) begin
      rb_wait--;
      if (rb_wait == 0) begin rb_n = 1'b0; rb_left = busy_len; end
    end else if (!rb_n) begin
      if (rb_left > 0) rb_left--;
      else begin rb_n = 1'b1; rb_rel = cyc; end
    end
    if (rdata_valid && rn < 64) begin rd[rn] = rdata; rn++; end
    pwe = we_n; pre = re_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int done_cyc;
  logic fail_s, tmo_s;

  task automatic run(input logic [2:0] op, input logic [11:0] col, input logic [15:0] row);
    int t;
    ln = 0; rn = 0; re_cnt = 0; rb_rel = -1;
    @(negedge clk);
    wk = 0;
    req_op = op; req_col = col; req_row = row; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "watchdog", t, 20000);
    done_cyc = cyc; fail_s = fail; tmo_s = tmo;
    @(negedge clk);
  endtask

  task automatic chk_byte(input int i, input int kind, input logic [7:0] b, input string req);
    chk(lb[i] == b, req, lb[i], b);
    chk(lk[i] == kind, {req, " kind"}, lk[i], kind);
  endtask

  task automatic t_reset_state;
    chk(ce_n && we_n && re_n, "R1 strobes", {ce_n, we_n, re_n}, 3'b111);
    chk(!cle && !ale && !dq_oe, "R1 latches", {cle, ale, dq_oe}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_read;
    busy_len = 30;
    run(3'd0, 12'hA5C, 16'h1234);
    chk(ln == 6, "R2 read byte count", ln, 6);
    chk_byte(0, 0, 8'h00, "R2 read cmd1");
    chk_byte(1, 1, 8'h5C, "R3 col lo");
    chk_byte(2, 1, 8'h0A, "R3 col hi");
    chk_byte(3, 1, 8'h34, "R3 row lo");
    chk_byte(4, 1, 8'h12, "R3 row hi");
    chk_byte(5, 0, 8'h30, "R2 read cmd2");
    chk(rb_rel > 0 && re_first > rb_rel, "R7 read after release", re_first, rb_rel);
    chk(re_cnt == PB, "R9 RE pulses", re_cnt, PB);
    chk(rn == PB, "R9 byte count", rn, PB);
    for (int i = 0; i < PB; i++) chk(rd[i] == rpat(i), "R9 data", rd[i], rpat(i));
  endtask

  task automatic t_prog;
    busy_len = 40; stat_byte = 8'hE0;
    run(3'd1, 12'h0FF, 16'hBEEF);
    chk(ln == 4 + PB + 3, "R12 program byte count", ln, 4 + PB + 3);
    chk_byte(0, 0, 8'h80, "R2 prog cmd1");
    chk_byte(1, 1, 8'hFF, "R3 col lo");
    chk_byte(2, 1, 8'h00, "R3 col hi");
    chk_byte(3, 1, 8'hEF, "R3 row lo");
    chk_byte(4, 1, 8'hBE, "R3 row hi");
    for (int i = 0; i < PB; i++) chk_byte(5 + i, 2, 8'(8'h40 + i), "R12 data");
    chk_byte(5 + PB, 0, 8'h10, "R2 prog cmd2");
    chk_byte(6 + PB, 0, 8'h70, "R10 status cmd");
    chk(lt[5] - lt[4] >= ADL, "R6 address-to-data gap", lt[5] - lt[4], ADL);
    chk(rb_rel > 0 && lt[6 + PB] > rb_rel, "R7 status after release", lt[6 + PB], rb_rel);
    chk(re_first - lt[6 + PB] >= WHR, "R8 write-to-read gap", re_first - lt[6 + PB], WHR);
    chk(fail_s == 1'b0 && tmo_s == 1'b0, "R10 pass", {fail_s, tmo_s}, 0);
  endtask

  task automatic t_erase_fail;
    busy_len = 25; stat_byte = 8'hE1;
    run(3'd2, 12'hFFF, 16'h0440);
    chk(ln == 5, "R4 erase byte count", ln, 5);
    chk_byte(0, 0, 8'h60, "R2 erase cmd1");
    chk_byte(1, 1, 8'h40, "R4 row lo");
    chk_byte(2, 1, 8'h04, "R4 row hi");
    chk_byte(3, 0, 8'hD0, "R2 erase cmd2");
    chk_byte(4, 0, 8'h70, "R10 status cmd");
    chk(fail_s == 1'b1, "R10 fail bit", fail_s, 1);
    chk(rn == 0, "R10 no stream on erase", rn, 0);
  endtask

  task automatic t_status;
    stat_byte = 8'hC3;
    run(3'd3, 12'h000, 16'h0000);
    chk(ln == 1, "R10 status alone", ln, 1);
    chk_byte(0, 0, 8'h70, "R2 status cmd");
    chk(rn == 1 && rd[0] == 8'hC3, "R10 status byte", rd[0], 8'hC3);
    chk(fail_s == 1'b1, "R10 status fail", fail_s, 1);
    chk(re_first - lt[0] >= WHR, "R8 status gap", re_first - lt[0], WHR);
  endtask

  task automatic t_id;
    run(3'd4, 12'h123, 16'h4567);
    chk(ln == 2, "R13 id byte count", ln, 2);
    chk_byte(0, 0, 8'h90, "R13 id cmd");
    chk_byte(1, 1, 8'h00, "R13 id addr");
    chk(rn == IDB, "R13 id bytes", rn, IDB);
    for (int i = 0; i < IDB; i++) chk(rd[i] == 8'(8'hA0 + i), "R13 id data", rd[i], 8'hA0 + i);
  endtask

  task automatic t_dev_reset;
    busy_len = 50;
    run(3'd5, 12'h000, 16'h0000);
    chk(ln == 1, "R14 reset byte count", ln, 1);
    chk_byte(0, 0, 8'hFF, "R14 reset cmd");
    chk(rb_rel > 0 && done_cyc > rb_rel, "R14 done after release", done_cyc, rb_rel);
    chk(tmo_s == 1'b0, "R14 no timeout", tmo_s, 0);
  endtask

  task automatic t_timeout;
    busy_len = 2000;
    run(3'd2, 12'h000, 16'h0101);
    chk(tmo_s == 1'b1, "R11 timeout flag", tmo_s, 1);
    chk(ln == 4, "R11 no status cmd", ln, 4);
    chk(done_cyc - lt[3] >= BMAX, "R11 timeout delay", done_cyc - lt[3], BMAX);
    chk(rb_n == 1'b0, "R11 device still busy", rb_n, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_read();
    t_prog();
    t_erase_fail();
    t_status();
    t_id();
    t_dev_reset();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL global watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule